// File: doc/BRIEF.md
# Four-Sensor Serial Thermometer Bridge

The block sits on a small host register bus and stands in for four three-wire serial temperature sensors that are worked in lock-step. Software drives a clock flag and data bits through two write registers to shift an 8-bit command into all four sensors at once. It then pulls result bits out of a read register, one bit position per read. Each read returns the current bit of every sensor, packed one sensor per result bit.

Each sensor's configuration and temperature value is held inside the block, so no external sensor pins are driven. Bits written after a command is complete are collected into a data accumulator. Every value written to the data-write register is also latched as the select code for a separate analog multiplexer that feeds a voltage converter.

Register addresses: 0 is control, 1 is data-write and 2 is data-read. A write takes priority over a read issued in the same cycle.

Top module: `thermo_bridge`

## Requirements
- R1: After rst_ni is released, rvalid_o, unk_o, rdata_o, mux_sel_o and wr_data_o are all zero, and the clock-low flag is clear.
- R2: A read, meaning rd_en_i high with wr_en_i low, sets rvalid_o for exactly one cycle on the next cycle. For a data-read (address 2) under an active read command, rdata_o bit i carries sensor i's bit at the current bit position.
- R3: Writing 0x02 to control (address 0) sets the clock-low flag, and writing 0x03 clears it. A data-write (address 1) other than 0x02 is accepted as a bit only while the flag is set. Other control values have no effect.
- R4: Command bits are gathered least-significant first over 8 accepted writes. The value 0x01 gives a 1 and any other accepted value gives a 0. Command 0xAA (read temperature) makes the next 9 reads stream each sensor's temperature value 44, least-significant bit first. After the 9th read the block is back in reset state.
- R5: Command 0xAC (read configuration) makes the next 8 reads stream each sensor's configuration value 0x02, least-significant bit first. After the 8th read the block is back in reset state.
- R6: When the 8th bit completes command 0xEE (start convert), the block returns to reset state. A following read is unknown, and the next 8 accepted bits form a new command.
- R7: Writing 0x01 to control clears the command, the command bit count, the data accumulator and the bit position. It leaves the clock-low flag unchanged.
- R8: A data-write of 0x02 resets the bit position to zero whatever the clock-low flag is, and it is not counted as a command bit.
- R9: Once a command is complete, each accepted data-write sets wr_data_o at the current bit position for 0x01 and leaves it zero otherwise. The position then advances, which also moves the position of later streamed reads.
- R10: Every data-write is latched onto mux_sel_o on the next cycle, accepted or not. mux_sel_o holds its value otherwise.
- R11: A data-read while no complete read command is active returns rdata_o zero and raises unk_o for one cycle alongside rvalid_o. It changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Host write strobe |
| rd_en_i | input | 1 | Host read strobe |
| addr_i | input | 2 | Register address: 0 control, 1 data-write, 2 data-read |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 4 | Read result, one bit per sensor |
| rvalid_o | output | 1 | Read result valid, one cycle after the read |
| unk_o | output | 1 | Read with no active read command |
| mux_sel_o | output | 8 | Last data-write value, multiplexer select |
| wr_data_o | output | 16 | Data accumulator |

## Verification
Read results come from a single register stage. rdata_o, rvalid_o and unk_o are therefore due one cycle after the cycle in which rd_en_i is sampled. mux_sel_o and wr_data_o also change one cycle after the write that caused the change. The driver queues each expected read result before it raises the strobe. The monitor samples on the falling edge that follows the capturing rising edge, and the write-side outputs are checked on that same falling edge after each write task returns. Ignored writes and the no-state-change rule are shown through later reads, which stream from the expected bit position only if nothing was disturbed.

// File: rtl/thermo_pkg.sv
package thermo_pkg;
  localparam int unsigned CMD_W = 8;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_DWR  = 2'd1;
  localparam logic [1:0] ADDR_DRD  = 2'd2;

  localparam logic [7:0] CTRL_RESET    = 8'h01;
  localparam logic [7:0] CTRL_CLK_LOW  = 8'h02;
  localparam logic [7:0] CTRL_CLK_HIGH = 8'h03;

  localparam logic [7:0] DW_HIGH    = 8'h01;
  localparam logic [7:0] DW_EN_READ = 8'h02;

  localparam logic [CMD_W-1:0] CMD_START   = 8'hEE;
  localparam logic [CMD_W-1:0] CMD_RD_CFG  = 8'hAC;
  localparam logic [CMD_W-1:0] CMD_RD_TEMP = 8'hAA;

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_CFG  = 2'd1,
    RD_TEMP = 2'd2
  } rd_kind_e;
endpackage

// File: rtl/thermo_sensor.sv
module thermo_sensor
  import thermo_pkg::*;
#(
  parameter int unsigned CFG_W  = 8,
  parameter int unsigned TEMP_W = 9,
  parameter int unsigned POS_W  = 5,
  parameter logic [CFG_W-1:0]  CFG_INIT  = '0,
  parameter logic [TEMP_W-1:0] TEMP_INIT = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [POS_W-1:0] pos_i,
  input  rd_kind_e         kind_i,
  output logic             bit_o
);
  logic [CFG_W-1:0]  cfg_q, cfg_sh;
  logic [TEMP_W-1:0] temp_q, temp_sh;

  // sensor registers: loaded on reset, held afterwards
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= CFG_INIT;
      temp_q <= TEMP_INIT;
    end else begin
      cfg_q  <= cfg_q;
      temp_q <= temp_q;
    end
  end

  assign cfg_sh  = cfg_q >> pos_i;
  assign temp_sh = temp_q >> pos_i;

  always_comb begin
    unique case (kind_i)
      RD_CFG:  bit_o = cfg_sh[0];
      RD_TEMP: bit_o = temp_sh[0];
      default: bit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/thermo_engine.sv
module thermo_engine
  import thermo_pkg::*;
#(
  parameter int unsigned DACC_W = 16,
  parameter int unsigned CFG_W  = 8,
  parameter int unsigned TEMP_W = 9,
  parameter int unsigned POS_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic              dwr_we_i,
  input  logic              rd_we_i,
  input  logic [7:0]        wdata_i,
  output logic [POS_W-1:0]  pos_o,
  output rd_kind_e          kind_o,
  output logic [DACC_W-1:0] dacc_o
);
  localparam int unsigned CPOS_W = $clog2(CMD_W + 1);

  logic [CMD_W-1:0]  cmd_q, cmd_nx;
  logic [CPOS_W-1:0] cpos_q;
  logic [DACC_W-1:0] dacc_q;
  logic [POS_W-1:0]  pos_q;
  logic              clk_low_q;
  logic              cmd_done, bit_high;

  assign cmd_done = (cpos_q == CPOS_W'(CMD_W));
  assign bit_high = (wdata_i == DW_HIGH);
  assign cmd_nx   = bit_high ? (cmd_q | (CMD_W'(1) << cpos_q)) : cmd_q;

  always_comb begin
    kind_o = RD_NONE;
    if (cmd_done) begin
      if (cmd_q == CMD_RD_CFG)  kind_o = RD_CFG;
      if (cmd_q == CMD_RD_TEMP) kind_o = RD_TEMP;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q     <= '0;
      cpos_q    <= '0;
      dacc_q    <= '0;
      pos_q     <= '0;
      clk_low_q <= 1'b0;
    end else if (ctrl_we_i) begin
      if (wdata_i == CTRL_RESET) begin
        cmd_q  <= '0;
        cpos_q <= '0;
        dacc_q <= '0;
        pos_q  <= '0;
      end else if (wdata_i == CTRL_CLK_LOW) begin
        clk_low_q <= 1'b1;
      end else if (wdata_i == CTRL_CLK_HIGH) begin
        clk_low_q <= 1'b0;
      end
    end else if (dwr_we_i) begin
      if (wdata_i == DW_EN_READ) begin
        pos_q <= '0;
      end else if (clk_low_q) begin
        if (!cmd_done) begin
          if (cpos_q == CPOS_W'(CMD_W - 1) && cmd_nx == CMD_START) begin
            cmd_q  <= '0;
            cpos_q <= '0;
            dacc_q <= '0;
            pos_q  <= '0;
          end else begin
            cmd_q  <= cmd_nx;
            cpos_q <= cpos_q + 1'b1;
          end
        end else if (pos_q < POS_W'(DACC_W)) begin
          if (bit_high) dacc_q <= dacc_q | (DACC_W'(1) << pos_q);
          pos_q <= pos_q + 1'b1;
        end
      end
    end else if (rd_we_i && kind_o != RD_NONE) begin
      // stream ends once the last bit of the selected register is out
      if ((kind_o == RD_CFG  && pos_q >= POS_W'(CFG_W - 1)) ||
          (kind_o == RD_TEMP && pos_q >= POS_W'(TEMP_W - 1))) begin
        cmd_q  <= '0;
        cpos_q <= '0;
        dacc_q <= '0;
        pos_q  <= '0;
      end else begin
        pos_q <= pos_q + 1'b1;
      end
    end
  end

  assign pos_o  = pos_q;
  assign dacc_o = dacc_q;
endmodule

// File: rtl/thermo_bridge.sv
module thermo_bridge
  import thermo_pkg::*;
#(
  parameter int unsigned N_SENS    = 4,
  parameter int unsigned CFG_W     = 8,
  parameter int unsigned TEMP_W    = 9,
  parameter int unsigned DACC_W    = 16,
  parameter logic [7:0]  CFG_INIT  = 8'h02,
  parameter int unsigned TEMP_DEGC = 22
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [1:0]        addr_i,
  input  logic [7:0]        wdata_i,
  output logic [N_SENS-1:0] rdata_o,
  output logic              rvalid_o,
  output logic              unk_o,
  output logic [7:0]        mux_sel_o,
  output logic [DACC_W-1:0] wr_data_o
);
  localparam int unsigned POS_W = $clog2(DACC_W + 1);
  localparam logic [TEMP_W-1:0] TEMP_INIT = TEMP_W'(TEMP_DEGC * 2);

  logic              ctrl_we, dwr_we, rd_any, rd_we;
  logic [POS_W-1:0]  pos;
  rd_kind_e          kind;
  logic [N_SENS-1:0] bits;

  assign ctrl_we = wr_en_i && (addr_i == ADDR_CTRL);
  assign dwr_we  = wr_en_i && (addr_i == ADDR_DWR);
  assign rd_any  = rd_en_i && !wr_en_i;
  assign rd_we   = rd_any && (addr_i == ADDR_DRD);

  thermo_engine #(
    .DACC_W(DACC_W), .CFG_W(CFG_W), .TEMP_W(TEMP_W), .POS_W(POS_W)
  ) u_engine (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ctrl_we_i(ctrl_we),
    .dwr_we_i (dwr_we),
    .rd_we_i  (rd_we),
    .wdata_i  (wdata_i),
    .pos_o    (pos),
    .kind_o   (kind),
    .dacc_o   (wr_data_o)
  );

  for (genvar g = 0; g < N_SENS; g++) begin : g_sens
    thermo_sensor #(
      .CFG_W(CFG_W), .TEMP_W(TEMP_W), .POS_W(POS_W),
      .CFG_INIT(CFG_W'(CFG_INIT)), .TEMP_INIT(TEMP_INIT)
    ) u_sens (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .pos_i (pos),
      .kind_i(kind),
      .bit_o (bits[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o   <= '0;
      rvalid_o  <= 1'b0;
      unk_o     <= 1'b0;
      mux_sel_o <= '0;
    end else begin
      rvalid_o <= rd_any;
      unk_o    <= rd_we && (kind == RD_NONE);
      rdata_o  <= (rd_we && kind != RD_NONE) ? bits : '0;
      if (dwr_we) mux_sel_o <= wdata_i;
    end
  end
endmodule

// File: rtl/thermo_bridge_chk.sv
module thermo_bridge_chk #(
  parameter int unsigned N_SENS = 4,
  parameter int unsigned DACC_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [1:0]        addr_i,
  input logic [7:0]        wdata_i,
  input logic [N_SENS-1:0] rdata_o,
  input logic              rvalid_o,
  input logic              unk_o,
  input logic [7:0]        mux_sel_o,
  input logic [DACC_W-1:0] wr_data_o
);
  assert_rvalid_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !wr_en_i) |=> rvalid_o);
  assert_rvalid_clr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_en_i && !wr_en_i) |=> !rvalid_o);
  assert_rdata_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rvalid_o |-> (rdata_o == '0));
  assert_unk_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unk_o |-> (rvalid_o && rdata_o == '0));
  assert_mux_latch_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 2'd1) |=> (mux_sel_o == $past(wdata_i)));
  assert_mux_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr_i == 2'd1) |=> $stable(mux_sel_o));
  assert_reset_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 2'd0 && wdata_i == 8'h01) |=> (wr_data_o == '0));
endmodule

bind thermo_bridge thermo_bridge_chk #(.N_SENS(N_SENS), .DACC_W(DACC_W)) u_chk (.*);

// File: tb/thermo_bridge_tb.sv
`timescale 1ns/100ps
module thermo_bridge_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [3:0]  rdata;
  logic        rvalid, unk;
  logic [7:0]  mux_sel;
  logic [15:0] wr_data;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  typedef struct { logic [3:0] d; logic u; string tag; } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  thermo_bridge u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid),
    .unk_o(unk), .mux_sel_o(mux_sel), .wr_data_o(wr_data)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // monitor: pops one expected item per valid read
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (sb.size() == 0) begin
        check("R2 unexpected rvalid", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check({e.tag, " rdata"}, {28'd0, rdata}, {28'd0, e.d});
        check({e.tag, " unk"}, {31'd0, unk}, {31'd0, e.u});
      end
    end
  end

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [3:0] d, logic u, string tag);
    exp_t e;
    e.d = d; e.u = u; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    rd_en = 1'b1; addr = 2'd2;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic send_bits(logic [7:0] b, int n, int from);
    for (int i = from; i < from + n; i++) wr(2'd1, b[i] ? 8'h01 : 8'h00);
  endtask

  // temperature 44 = 9'b000101100, LSB first, all sensors alike
  function automatic logic [3:0] tbit(int i);
    logic [8:0] t = 9'd44;
    return t[i] ? 4'hF : 4'h0;
  endfunction

  initial begin
    #200000;
    check("watchdog expired", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 rvalid", {31'd0, rvalid}, 0);
    check("R1 unk", {31'd0, unk}, 0);
    check("R1 rdata", {28'd0, rdata}, 0);
    check("R1 mux_sel", {24'd0, mux_sel}, 0);
    check("R1 wr_data", {16'd0, wr_data}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 read with no command
    rd(4'h0, 1'b1, "R11 idle read");
    // R1 clock flag clear after reset: bits ignored
    send_bits(8'hAA, 8, 0);
    rd(4'h0, 1'b1, "R1 flag clear ignores bits");
    check("R10 mux after ignored bit", {24'd0, mux_sel}, 32'h01);

    // R4 read temperature
    wr(2'd0, 8'h02);
    send_bits(8'hAA, 8, 0);
    for (int i = 0; i < 9; i++) rd(tbit(i), 1'b0, "R4 temp stream");
    rd(4'h0, 1'b1, "R4 reset after temp");

    // R3 clock high blocks bits, other control value no effect
    wr(2'd0, 8'h03);
    wr(2'd0, 8'h55);
    send_bits(8'hAC, 8, 0);
    rd(4'h0, 1'b1, "R3 bits blocked");
    // R5 read configuration 0x02
    wr(2'd0, 8'h02);
    send_bits(8'hAC, 8, 0);
    for (int i = 0; i < 8; i++) rd((i == 1) ? 4'hF : 4'h0, 1'b0, "R5 cfg stream");
    rd(4'h0, 1'b1, "R5 reset after cfg");

    // R8 enable-read resets position while flag high
    send_bits(8'hAA, 8, 0);
    for (int i = 0; i < 3; i++) rd(tbit(i), 1'b0, "R8 before");
    wr(2'd0, 8'h03);
    wr(2'd1, 8'h02);
    check("R10 mux enable-read", {24'd0, mux_sel}, 32'h02);
    for (int i = 0; i < 3; i++) rd(tbit(i), 1'b0, "R8 restart");
    // R9 data bits at current position 3
    wr(2'd0, 8'h02);
    wr(2'd1, 8'h01);
    wr(2'd1, 8'h00);
    wr(2'd1, 8'h01);
    check("R9 wr_data", {16'd0, wr_data}, 32'h0028);
    rd(tbit(6), 1'b0, "R9 position moved");
    // R7 reset code clears, flag kept
    wr(2'd0, 8'h01);
    check("R7 wr_data cleared", {16'd0, wr_data}, 0);
    rd(4'h0, 1'b1, "R7 command cleared");
    send_bits(8'hAA, 8, 0);
    rd(tbit(0), 1'b0, "R7 flag kept");
    wr(2'd0, 8'h01);

    // R6 start convert then new command
    send_bits(8'hEE, 8, 0);
    rd(4'h0, 1'b1, "R6 after start");
    send_bits(8'hAA, 8, 0);
    rd(tbit(0), 1'b0, "R6 new command");
    rd(tbit(1), 1'b0, "R6 new command");
    wr(2'd0, 8'h01);

    // R11 read mid-command changes nothing; R8 enable-read not counted
    send_bits(8'hAA, 4, 0);
    rd(4'h0, 1'b1, "R11 partial command");
    wr(2'd1, 8'h02);
    send_bits(8'hAA, 4, 4);
    rd(tbit(0), 1'b0, "R11 command intact");
    rd(tbit(1), 1'b0, "R11 command intact");
    rd(tbit(2), 1'b0, "R2 packed bits");
    check("R10 mux last", {24'd0, mux_sel}, 32'h01);

    repeat (4) @(negedge clk);
    check("R2 scoreboard drained", sb.size(), 0);
    finish_run();
  end
endmodule